// File: doc/BRIEF.md
# Programmable Pin Function Crossbar

This block sits between a chip's package pins and its on-chip peripherals. Any of 48 pins can carry any of 256 peripheral functions. Each pin owns one configuration word. The word's low byte names the function the pin serves. Its other fields gate and invert that function's enable and data on their way to the pad, and store the electrical settings the pad needs. The function number works in both directions: the pin drives the pad from the chosen function, and it also feeds the pad level back to that same function.

On the input side, every function receives either the level of the pin mapped to it or a constant forced by software. Two banks of per-function bits hold the constants: one bank says whether a function is forced, the other gives the forced value. Software reaches every configuration word and both banks through a single word-addressed read/write port. Writes land on the next clock edge. Reads are combinational.

Top module: `pxb_crossbar`

## Requirements
- R1: The word address map is fixed. Words 0..47 are the pin words. Words 48..55 are the force-enable bank and words 56..63 the force-value bank; in each bank, word 48+k (or 56+k) bit j belongs to function 32k+j. An address of 64 or above reads 0, and a write to it changes nothing.
- R2: A write to a pin word shows on read from the next cycle on. Bits 23:0 read back as written, except bit 18. Bits 18 and 30:24 always read 0. Bit 31 reads the live level of that pin's pad input, before any inversion.
- R3: A pin's output enable equals bit 12 AND (bit 13 XOR fn_oe[s]), where s is bits 7:0 of that pin word.
- R4: A pin's output data is fn_oe[s] when bit 14 is set and fn_out[s] otherwise. The result is then inverted when bit 15 is set.
- R5: A pin's input enable equals bit 20 AND (bit 21 XOR fn_oe[s]).
- R6: An unforced function f receives pad_in[p] XOR bit 22 of pin p, taking the highest-numbered pin p that has its input enable high and s equal to f. If no pin qualifies, f receives 0.
- R7: A function whose force-enable bit is 1 receives its force-value bit, whatever any pin selects.
- R8: Pin word bits 11:8 reach that pin's 4-bit drive field unchanged. Bits 16, 17, 19 and 23 reach the pull-up, pull-down, slow-slew and Schmitt outputs.
- R9: After reset every pin word and both banks are zero. Every pad output enable and input enable is 0, and every function input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| fn_out | input | 256 | Data output of each function |
| fn_oe | input | 256 | Enable signal of each function |
| fn_in | output | 256 | Data delivered to each function |
| pad_in | input | 48 | Level seen at each pad |
| pad_out | output | 48 | Data driven to each pad |
| pad_oe | output | 48 | Output enable of each pad |
| pad_ie | output | 48 | Input enable of each pad |
| pad_drive | output | 192 | 4-bit drive code per pad, pin p at bits 4p+3:4p |
| pad_pull_up | output | 48 | Pull-up request per pad |
| pad_pull_dn | output | 48 | Pull-down request per pad |
| pad_slow | output | 48 | Reduced-slew request per pad |
| pad_schmitt | output | 48 | Schmitt input request per pad |

## Verification
The checker assumes that reg_addr and reg_wdata are stable and known over each clock edge. The write-readback property also assumes the address is held for one cycle after the write, or else moves away from the written word. The assertions are disabled until the internal reset synchronizer releases, so the bench waits several cycles after rst_n rises before its first write. The bench changes every input only at the falling edge, and it picks function numbers from a small range so that several pins often select the same function and the priority rule is exercised.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int CFG_W     = 32;
  localparam int DRV_LO    = 8;
  localparam int DRV_W     = 4;
  localparam int B_OE      = 12;
  localparam int B_OE_INV  = 13;
  localparam int B_DO_SEL  = 14;
  localparam int B_DO_INV  = 15;
  localparam int B_PU      = 16;
  localparam int B_PD      = 17;
  localparam int B_SLEW    = 19;
  localparam int B_IE      = 20;
  localparam int B_IE_INV  = 21;
  localparam int B_DI_INV  = 22;
  localparam int B_SCHMITT = 23;
  localparam int B_RAW     = 31;
  // fields that are stored; all other bits read as zero
  localparam logic [CFG_W-1:0] CFG_KEEP = 32'h00FB_FFFF;
  localparam int TIE_BITS  = 32;
endpackage

// File: rtl/pxb_regfile.sv
module pxb_regfile
  import pxb_pkg::*;
#(
  parameter int NPIN  = 48,
  parameter int NFUNC = 256,
  parameter int AW    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               addr,
  input  logic [CFG_W-1:0]            wdata,
  input  logic [NPIN-1:0]             pad_in,
  output logic [NPIN-1:0][CFG_W-1:0]  cfg,
  output logic [NFUNC-1:0]            tie_en,
  output logic [NFUNC-1:0]            tie_val,
  output logic [CFG_W-1:0]            rdata
);
  localparam int TW       = NFUNC / TIE_BITS;
  localparam int EN_BASE  = NPIN;
  localparam int VAL_BASE = NPIN + TW;

  logic [NPIN-1:0][CFG_W-1:0] cfg_q, cfg_d;
  logic [NFUNC-1:0]           ten_q, ten_d, tval_q, tval_d;

  // next state
  always_comb begin
    cfg_d  = cfg_q;
    ten_d  = ten_q;
    tval_d = tval_q;
    for (int p = 0; p < NPIN; p++) begin
      if (addr == AW'(p)) cfg_d[p] = wdata & CFG_KEEP;
    end
    for (int w = 0; w < TW; w++) begin
      if (addr == AW'(EN_BASE + w))  ten_d[w*TIE_BITS +: TIE_BITS]  = wdata;
      if (addr == AW'(VAL_BASE + w)) tval_d[w*TIE_BITS +: TIE_BITS] = wdata;
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ten_q  <= '0;
      tval_q <= '0;
    end else if (wr_en) begin
      cfg_q  <= cfg_d;
      ten_q  <= ten_d;
      tval_q <= tval_d;
    end
  end

  // read path
  always_comb begin
    rdata = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (addr == AW'(p)) begin
        rdata        = cfg_q[p];
        rdata[B_RAW] = pad_in[p];
      end
    end
    for (int w = 0; w < TW; w++) begin
      if (addr == AW'(EN_BASE + w))  rdata = ten_q[w*TIE_BITS +: TIE_BITS];
      if (addr == AW'(VAL_BASE + w)) rdata = tval_q[w*TIE_BITS +: TIE_BITS];
    end
  end

  assign cfg     = cfg_q;
  assign tie_en  = ten_q;
  assign tie_val = tval_q;
endmodule

// File: rtl/pxb_pin_ctl.sv
module pxb_pin_ctl
  import pxb_pkg::*;
#(
  parameter int NPIN  = 48,
  parameter int NFUNC = 256,
  localparam int FSEL_W = $clog2(NFUNC)
) (
  input  logic [NPIN-1:0][CFG_W-1:0]  cfg,
  input  logic [NFUNC-1:0]            fn_out,
  input  logic [NFUNC-1:0]            fn_oe,
  input  logic [NPIN-1:0]             pad_in,
  output logic [NPIN-1:0]             pad_out,
  output logic [NPIN-1:0]             pad_oe,
  output logic [NPIN-1:0]             pad_ie,
  output logic [NPIN*DRV_W-1:0]       pad_drive,
  output logic [NPIN-1:0]             pad_pull_up,
  output logic [NPIN-1:0]             pad_pull_dn,
  output logic [NPIN-1:0]             pad_slow,
  output logic [NPIN-1:0]             pad_schmitt,
  output logic [NPIN-1:0][FSEL_W-1:0] pin_sel,
  output logic [NPIN-1:0]             rx_data
);
  logic [NPIN-1:0] unused_hi;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [FSEL_W-1:0] sel;
    logic              f_oe;
    logic              f_dat;

    assign sel   = cfg[p][FSEL_W-1:0];
    assign f_oe  = fn_oe[sel];
    assign f_dat = cfg[p][B_DO_SEL] ? f_oe : fn_out[sel];

    assign pad_oe[p]  = cfg[p][B_OE] & (cfg[p][B_OE_INV] ^ f_oe);
    assign pad_ie[p]  = cfg[p][B_IE] & (cfg[p][B_IE_INV] ^ f_oe);
    assign pad_out[p] = f_dat ^ cfg[p][B_DO_INV];

    assign pad_drive[p*DRV_W +: DRV_W] = cfg[p][DRV_LO +: DRV_W];
    assign pad_pull_up[p] = cfg[p][B_PU];
    assign pad_pull_dn[p] = cfg[p][B_PD];
    assign pad_slow[p]    = cfg[p][B_SLEW];
    assign pad_schmitt[p] = cfg[p][B_SCHMITT];

    assign pin_sel[p] = sel;
    assign rx_data[p] = pad_in[p] ^ cfg[p][B_DI_INV];
    assign unused_hi[p] = ^{cfg[p][CFG_W-1:B_SCHMITT+1], cfg[p][18],
                            cfg[p][DRV_LO-1:FSEL_W]};
  end
endmodule

// File: rtl/pxb_fn_route.sv
module pxb_fn_route #(
  parameter int NPIN  = 48,
  parameter int NFUNC = 256,
  localparam int FSEL_W = $clog2(NFUNC)
) (
  input  logic [NPIN-1:0][FSEL_W-1:0] pin_sel,
  input  logic [NPIN-1:0]             pin_ie,
  input  logic [NPIN-1:0]             rx_data,
  input  logic [NFUNC-1:0]            tie_en,
  input  logic [NFUNC-1:0]            tie_val,
  output logic [NFUNC-1:0]            fn_in
);
  logic [NFUNC-1:0] routed;

  // later pins overwrite earlier ones: highest enabled pin wins
  always_comb begin
    routed = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (pin_ie[p]) routed[pin_sel[p]] = rx_data[p];
    end
  end

  assign fn_in = (tie_en & tie_val) | (~tie_en & routed);
endmodule

// File: rtl/pxb_crossbar.sv
module pxb_crossbar
  import pxb_pkg::*;
#(
  parameter int NPIN  = 48,
  parameter int NFUNC = 256,
  parameter int AW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [CFG_W-1:0]      reg_wdata,
  output logic [CFG_W-1:0]      reg_rdata,
  input  logic [NFUNC-1:0]      fn_out,
  input  logic [NFUNC-1:0]      fn_oe,
  output logic [NFUNC-1:0]      fn_in,
  input  logic [NPIN-1:0]       pad_in,
  output logic [NPIN-1:0]       pad_out,
  output logic [NPIN-1:0]       pad_oe,
  output logic [NPIN-1:0]       pad_ie,
  output logic [NPIN*DRV_W-1:0] pad_drive,
  output logic [NPIN-1:0]       pad_pull_up,
  output logic [NPIN-1:0]       pad_pull_dn,
  output logic [NPIN-1:0]       pad_slow,
  output logic [NPIN-1:0]       pad_schmitt
);
  localparam int FSEL_W = $clog2(NFUNC);

  logic [1:0]                 rst_sync;
  logic                       rst_core_n;
  logic [NPIN-1:0][CFG_W-1:0] pin_cfg;
  logic [NFUNC-1:0]           tie_en, tie_val;
  logic [NPIN-1:0][FSEL_W-1:0] pin_sel;
  logic [NPIN-1:0]            rx_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  pxb_regfile #(.NPIN(NPIN), .NFUNC(NFUNC), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .pad_in(pad_in), .cfg(pin_cfg),
    .tie_en(tie_en), .tie_val(tie_val), .rdata(reg_rdata)
  );

  pxb_pin_ctl #(.NPIN(NPIN), .NFUNC(NFUNC)) u_pins (
    .cfg(pin_cfg), .fn_out(fn_out), .fn_oe(fn_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
    .pad_drive(pad_drive), .pad_pull_up(pad_pull_up),
    .pad_pull_dn(pad_pull_dn), .pad_slow(pad_slow),
    .pad_schmitt(pad_schmitt), .pin_sel(pin_sel), .rx_data(rx_data)
  );

  pxb_fn_route #(.NPIN(NPIN), .NFUNC(NFUNC)) u_route (
    .pin_sel(pin_sel), .pin_ie(pad_ie), .rx_data(rx_data),
    .tie_en(tie_en), .tie_val(tie_val), .fn_in(fn_in)
  );
endmodule

// File: rtl/pxb_crossbar_chk.sv
module pxb_crossbar_chk
  import pxb_pkg::*;
#(
  parameter int NPIN  = 48,
  parameter int NFUNC = 256,
  parameter int AW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_we,
  input logic [AW-1:0]              reg_addr,
  input logic [CFG_W-1:0]           reg_wdata,
  input logic [CFG_W-1:0]           reg_rdata,
  input logic [NPIN-1:0]            pad_in,
  input logic [NPIN-1:0]            pad_oe,
  input logic [NFUNC-1:0]           fn_in,
  input logic [NPIN-1:0][CFG_W-1:0] cfg,
  input logic [NFUNC-1:0]           tie_en,
  input logic [NFUNC-1:0]           tie_val
);
  localparam int MAP_WORDS = NPIN + 2 * (NFUNC / TIE_BITS);
  localparam int PW        = $clog2(NPIN);

  logic unused_cfg;
  always_comb begin
    unused_cfg = 1'b0;
    for (int p = 0; p < NPIN; p++) unused_cfg ^= ^cfg[p];
  end

  // R1
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= MAP_WORDS) |-> (reg_rdata == '0));

  // R2
  raw_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) < NPIN) |-> (reg_rdata[B_RAW] == pad_in[reg_addr[PW-1:0]]));

  // R2
  write_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && int'(reg_addr) < NPIN) |=>
      ((reg_addr != $past(reg_addr)) ||
       (reg_rdata[CFG_W-2:0] == ($past(reg_wdata[CFG_W-2:0]) & CFG_KEEP[CFG_W-2:0]))));

  for (genvar p = 0; p < NPIN; p++) begin : g_pin_chk
    // R3
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg[p][B_OE] |-> !pad_oe[p]);
  end

  for (genvar f = 0; f < NFUNC; f++) begin : g_fn_chk
    // R7
    tie_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tie_en[f] |-> (fn_in[f] == tie_val[f]));
  end
endmodule

bind pxb_crossbar pxb_crossbar_chk #(.NPIN(NPIN), .NFUNC(NFUNC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
  .pad_oe(pad_oe), .fn_in(fn_in), .cfg(pin_cfg), .tie_en(tie_en),
  .tie_val(tie_val)
);

// File: tb/tb_pxb_crossbar.sv
module tb_pxb_crossbar;
  localparam int CLK_P = 10;
  localparam int NP = 48;
  localparam int NF = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NF-1:0] fn_out, fn_oe, fn_in;
  logic [NP-1:0] pad_in, pad_out, pad_oe, pad_ie;
  logic [NP*4-1:0] pad_drive;
  logic [NP-1:0] pad_pull_up, pad_pull_dn, pad_slow, pad_schmitt;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // model state
  logic [31:0] m_cfg [NP];
  logic [NF-1:0] m_ten, m_tval;

  always #(CLK_P/2) clk = ~clk;

  pxb_crossbar dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fn_out(fn_out),
    .fn_oe(fn_oe), .fn_in(fn_in), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_drive(pad_drive),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn),
    .pad_slow(pad_slow), .pad_schmitt(pad_schmitt)
  );

  task automatic chk(string tag, string what, logic [NF-1:0] act, logic [NF-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [NP-1:0] e_oe, e_out, e_ie, e_pu, e_pd, e_sl, e_st;
    logic [NP*4-1:0] e_drv;
    logic [NF-1:0] e_route;
    logic [31:0] e_rd;
    int a;
    for (int p = 0; p < NP; p++) begin
      int s;
      s = int'(m_cfg[p][7:0]);
      e_oe[p]  = m_cfg[p][12] & (m_cfg[p][13] ^ fn_oe[s]);
      e_ie[p]  = m_cfg[p][20] & (m_cfg[p][21] ^ fn_oe[s]);
      e_out[p] = (m_cfg[p][14] ? fn_oe[s] : fn_out[s]) ^ m_cfg[p][15];
      e_drv[p*4 +: 4] = m_cfg[p][11:8];
      e_pu[p] = m_cfg[p][16];
      e_pd[p] = m_cfg[p][17];
      e_sl[p] = m_cfg[p][19];
      e_st[p] = m_cfg[p][23];
    end
    for (int f = 0; f < NF; f++) begin
      e_route[f] = 1'b0;
      for (int p = NP - 1; p >= 0; p--) begin
        if (e_ie[p] && int'(m_cfg[p][7:0]) == f) begin
          e_route[f] = pad_in[p] ^ m_cfg[p][22];
          break;
        end
      end
    end
    a = int'(reg_addr);
    if (a < NP) e_rd = {pad_in[a], m_cfg[a][30:0]};
    else if (a < NP + 8) e_rd = m_ten[(a-NP)*32 +: 32];
    else if (a < NP + 16) e_rd = m_tval[(a-NP-8)*32 +: 32];
    else e_rd = 32'h0;

    chk("R3", "pad_oe", NF'(pad_oe), NF'(e_oe));
    chk("R4", "pad_out", NF'(pad_out), NF'(e_out));
    chk("R5", "pad_ie", NF'(pad_ie), NF'(e_ie));
    chk("R6", "fn_in routed", fn_in & ~m_ten, e_route & ~m_ten);
    chk("R7", "fn_in forced", fn_in & m_ten, m_tval & m_ten);
    chk("R8", "pad_drive", NF'(pad_drive), NF'(e_drv));
    chk("R8", "pull/slew/schmitt", NF'({pad_pull_up, pad_pull_dn, pad_slow, pad_schmitt}),
        NF'({e_pu, e_pd, e_sl, e_st}));
    if (a < NP) chk("R2", "pin word read", NF'(reg_rdata), NF'(e_rd));
    else        chk("R1", "map read", NF'(reg_rdata), NF'(e_rd));
  endtask

  // one clock: drive at falling edge, compare, update model after rising edge
  task automatic cycle(input logic we, input logic [7:0] a, input logic [31:0] d);
    reg_we = we; reg_addr = a; reg_wdata = d;
    for (int w = 0; w < NF/32; w++) begin
      fn_out[w*32 +: 32] = $urandom;
      fn_oe[w*32 +: 32]  = $urandom;
    end
    pad_in = {$urandom, $urandom};
    #(CLK_P/4);
    compare();
    @(posedge clk);
    if (we) begin
      int ai;
      ai = int'(a);
      if (ai < NP) m_cfg[ai] = d & 32'h00FB_FFFF;
      else if (ai < NP + 8) m_ten[(ai-NP)*32 +: 32] = d;
      else if (ai < NP + 16) m_tval[(ai-NP-8)*32 +: 32] = d;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    for (int p = 0; p < NP; p++) m_cfg[p] = '0;
    m_ten = '0; m_tval = '0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    fn_out = '0; fn_oe = '0; pad_in = '0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) cycle(1'b0, 8'd0, 32'h0);
    // R9: reset state
    #(CLK_P/4);
    chk("R9", "reset pad_oe", NF'(pad_oe), '0);
    chk("R9", "reset pad_ie", NF'(pad_ie), '0);
    chk("R9", "reset fn_in", fn_in, '0);
    chk("R9", "reset word", NF'(reg_rdata[30:0]), '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cycle(1'b0, 8'(i), 32'h0);

    // R2: full-ones write then read back each pin word
    for (int p = 0; p < NP; p++) begin
      cycle(1'b1, 8'(p), 32'hFFFF_FFFF);
      cycle(1'b0, 8'(p), 32'h0);
    end
    // R3 R4 R5 R6 R8: random pin words, functions crowded into 0..7
    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      d = $urandom;
      d[7:0] = 8'($urandom % 8);
      cycle(1'b1, 8'($urandom % NP), d);
      cycle(1'b0, 8'($urandom % 64), 32'h0);
    end
    // R7: force banks
    for (int i = 0; i < 200; i++) begin
      cycle(1'b1, 8'(NP + ($urandom % 16)), $urandom);
      cycle(1'b0, 8'(NP + ($urandom % 16)), 32'h0);
    end
    // R1: writes outside the map change nothing
    for (int i = 0; i < 200; i++) cycle(1'b1, 8'(64 + ($urandom % 192)), $urandom);
    for (int a = 0; a < 256; a++) cycle(1'b0, 8'(a), 32'h0);
    // R6: release all forces, then route again
    for (int w = 0; w < 8; w++) cycle(1'b1, 8'(NP + w), 32'h0);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      d = $urandom;
      d[7:0] = 8'($urandom % 4);
      d[20] = 1'b1;
      cycle(1'b1, 8'($urandom % NP), d);
    end
    summary();
  end
endmodule